// File: doc/BRIEF.md
# Write-Once Append-Only Record Log Controller

This controller sits between user logic and a write-once, single-port, non-volatile word array whose blank cells read as all ones. It makes that storage look rewritable: every new record is appended at the first blank location and nothing is ever programmed twice. The most recent record is always the one that ends just below the append pointer. A record spans `RECW` consecutive words of `DATA_W` bits each, where `DATA_W` is 16, 32 or 64. After every reset the controller rebuilds the append pointer by scanning the array from address 0.

Each stored word carries a used-marker bit and single-error-correct / double-error-detect check bits. The whole stored word is kept in inverted form, so a blank cell decodes as a clean, unused word. Programming one word is slow: it takes `PGM_CYC` cycles, about 50 us in the target. The controller is busy for the whole program time, and a read request that arrives meanwhile is parked in a one-entry slot until the array is free. A write-once lock bit can be set by user logic. Once it is set, reads marked as external are refused, while on-chip reads are still served.

Top module: `otp_append_log`

## Requirements
- R1: From reset, `busy` is high while the controller scans the array from address 0 upward. The append pointer becomes the address of the first blank word, which reads as all ones, or `DEPTH` if no word is blank. A record whose data is all ones still counts as used.
- R2: An accepted write programs `RECW` words in ascending address order, starting at the append pointer. Word k carries `wrData[k*DATA_W +: DATA_W]`. No address is ever programmed twice, and the pointer then advances by `RECW`.
- R3: Each word is programmed with `memPgmEn` held at one address for exactly `PGM_CYC` cycles. `busy` is high throughout, and `memRdEn` is never high while `memPgmEn` is high.
- R4: A read request made while a word is being programmed is held and served only after the whole record has been written.
- R5: A read-latest request returns the record that occupies the `RECW` words just below the append pointer, with a one-cycle `rdValid` pulse. When no record is stored, it gives a one-cycle `rdErr` pulse and no `rdValid`.
- R6: A read-by-index request for record i returns the words at addresses i*`RECW` upward. An index whose record lies at or beyond the append pointer gives `rdErr` and no `rdValid`.
- R7: A single flipped bit in any stored word is corrected on read, with `rdUncorr` low.
- R8: Two flipped bits in one stored word of a record raise `rdUncorr` together with that record's `rdValid`.
- R9: `full` is high when fewer than `RECW` blank words remain. A write request while `full` or `busy` is high gives a `wrErr` pulse on the next cycle and programs nothing.
- R10: A `lockReq` pulse sets a lock that no input can clear. Afterwards, reads with `rdExt` high are refused with `rdErr`, and reads with `rdExt` low are served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; starts the array scan |
| wrReq | input | 1 | Append-record request, one cycle |
| wrData | input | DATA_W*RECW | Record to append, word 0 in the low bits |
| wrErr | output | 1 | Write refused (full or busy), one cycle |
| rdLatestReq | input | 1 | Request the newest record |
| rdIdxReq | input | 1 | Request record number `rdIdx` |
| rdIdx | input | clog2(DEPTH) | Record index for an indexed read |
| rdExt | input | 1 | Marks the read as coming from outside the chip |
| rdValid | output | 1 | `rdData` and `rdUncorr` valid, one cycle |
| rdData | output | DATA_W*RECW | Record returned by the last read |
| rdUncorr | output | 1 | Some word of the returned record had a double-bit error |
| rdErr | output | 1 | Read refused (empty, out of range or locked), one cycle |
| lockReq | input | 1 | Set the external-read lock |
| busy | output | 1 | Scan, program or read in progress, or read pending |
| full | output | 1 | No room for another record |
| memAddr | output | clog2(DEPTH) | Array word address |
| memRdEn | output | 1 | Array read; data returns on the next cycle |
| memRdData | input | CWW | Stored word read from the array |
| memPgmEn | output | 1 | Array program pulse, held for the program time |
| memPgmData | output | CWW | Stored word to program (zero bits get burnt) |

## Verification
The hardest situations to reach from the ports are a read arriving in the middle of a multi-word program, and an append pointer that must be rebuilt from an array that already holds data. The bench keeps its own write-once array model alive across a reset, so the post-reset scan sees real records, including one whose data is all ones. It also issues an indexed read and a second write while a record is still being programmed. Corrupted words are produced by flipping single and double bits directly in the model's cells between a write and the read that follows it.

// File: rtl/otp_log_pkg.sv
package otp_log_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadWr;   // capture the record to be programmed
    logic capWord;  // store one decoded word into the read buffer
    logic clrRd;    // start of a record read
  } dpStrobe_t;

  // number of Hamming check bits for dw data bits
  function automatic int eccChkBits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/otp_log_dp.sv
module otp_log_dp
  import otp_log_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RECW   = 7,
  parameter int KW     = 3,
  localparam int DW1   = DATA_W + 1,
  localparam int P     = eccChkBits(DW1),
  localparam int N     = DW1 + P,
  localparam int REC_BITS = DATA_W * RECW
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [KW-1:0]       wordSel,
  input  logic [REC_BITS-1:0] wrData,
  input  logic [N:0]          memRdData,
  output logic [N:0]          memPgmData,
  output logic                blank,
  output logic [REC_BITS-1:0] rdData,
  output logic                rdUncorr
);

  logic [REC_BITS-1:0] wrBuf;
  logic [DW1-1:0]      decWord;
  logic                dblErr;

  // Hamming code over positions 1..N, overall parity in bit 0
  function automatic logic [N:0] hamEnc(input logic [DW1-1:0] d);
    logic [N:0] c;
    logic       x;
    int         j;
    c = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int i = 0; i < P; i++) begin
      x = 1'b0;
      for (int p = 1; p <= N; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) x ^= c[p];
      c[1 << i] = x;
    end
    c[0] = ^c[N:1];
    return c;
  endfunction

  // stored form is inverted so that an erased (all ones) cell is a clean,
  // unused word; marker bit 0 means the word holds data
  always_comb begin
    memPgmData = ~hamEnc(~{1'b0, wrBuf[wordSel*DATA_W +: DATA_W]});
  end

  always_comb begin
    logic [N:0]     cw;
    logic [P-1:0]   syn;
    logic           ovr;
    logic [DW1-1:0] dx;
    int             j;
    cw  = ~memRdData;
    syn = '0;
    for (int p = 1; p <= N; p++)
      if (cw[p]) syn ^= P'(p);
    ovr    = ^cw;
    dblErr = (syn != '0) && !ovr;
    if ((syn != '0) && ovr && (int'(syn) <= N)) cw[syn] = ~cw[syn];
    dx = '0;
    j  = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        dx[j] = cw[p];
        j++;
      end
    end
    decWord = ~dx;
  end

  assign blank = decWord[DW1-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBuf    <= '0;
      rdData   <= '0;
      rdUncorr <= 1'b0;
    end else begin
      if (strobe.loadWr) wrBuf <= wrData;
      if (strobe.clrRd) rdUncorr <= 1'b0;
      if (strobe.capWord) begin
        rdData[wordSel*DATA_W +: DATA_W] <= decWord[DATA_W-1:0];
        if (dblErr) rdUncorr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/otp_log_ctrl.sv
module otp_log_ctrl
  import otp_log_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int RECW    = 7,
  parameter int PGM_CYC = 10000,
  parameter int MAW     = 6,
  parameter int KW      = 3,
  localparam int AW     = $clog2(DEPTH + 1),
  localparam int CNTW   = $clog2(PGM_CYC + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrReq,
  output logic           wrErr,
  input  logic           rdLatestReq,
  input  logic           rdIdxReq,
  input  logic [MAW-1:0] rdIdx,
  input  logic           rdExt,
  output logic           rdValid,
  output logic           rdErr,
  input  logic           lockReq,
  output logic           busy,
  output logic           full,
  input  logic           blank,
  output dpStrobe_t      strobe,
  output logic [KW-1:0]  wordSel,
  output logic [MAW-1:0] memAddr,
  output logic           memRdEn,
  output logic           memPgmEn
);

  typedef enum logic [2:0] {
    S_SCAN_ISS, S_SCAN_CAP, S_IDLE, S_PGM, S_RD_ISS, S_RD_CAP, S_RD_DONE
  } state_t;

  state_t          st;
  logic [AW-1:0]   nextFree, curAddr, baseW;
  logic [KW-1:0]   wordIdx;
  logic [CNTW-1:0] pgmCnt;
  logic            slotV, slotLatest, slotExt, locked;
  logic [MAW-1:0]  slotIdx;
  logic [31:0]     idxBase;
  logic            rdOk, wrAccept, lastWord, pgmLast;

  assign lastWord = (wordIdx == KW'(RECW - 1));
  assign pgmLast  = (pgmCnt == CNTW'(PGM_CYC - 1));
  assign full     = (32'(DEPTH) - 32'(nextFree)) < 32'(RECW);
  assign busy     = (st != S_IDLE) || slotV;
  assign wrAccept = (st == S_IDLE) && !slotV && wrReq && !full;

  always_comb begin
    idxBase = 32'(slotIdx) * 32'(RECW);
    if (slotLatest) begin
      rdOk  = 32'(nextFree) >= 32'(RECW);
      baseW = nextFree - AW'(RECW);
    end else begin
      rdOk  = (idxBase + 32'(RECW)) <= 32'(nextFree);
      baseW = AW'(idxBase);
    end
    if (slotExt && locked) rdOk = 1'b0;
  end

  assign memRdEn        = (st == S_SCAN_ISS) || (st == S_RD_ISS);
  assign memPgmEn       = (st == S_PGM);
  assign memAddr        = curAddr[MAW-1:0];
  assign wordSel        = wordIdx;
  assign rdValid        = (st == S_RD_DONE);
  assign strobe.loadWr  = wrAccept;
  assign strobe.capWord = (st == S_RD_CAP);
  assign strobe.clrRd   = (st == S_IDLE) && slotV && rdOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= S_SCAN_ISS;
      nextFree   <= '0;
      curAddr    <= '0;
      wordIdx    <= '0;
      pgmCnt     <= '0;
      slotV      <= 1'b0;
      slotLatest <= 1'b0;
      slotExt    <= 1'b0;
      slotIdx    <= '0;
      locked     <= 1'b0;
      rdErr      <= 1'b0;
      wrErr      <= 1'b0;
    end else begin
      wrErr <= wrReq && (busy || full);
      rdErr <= 1'b0;
      if (lockReq) locked <= 1'b1;
      if (!slotV && (rdLatestReq || rdIdxReq)) begin
        slotV      <= 1'b1;
        slotLatest <= rdLatestReq;
        slotIdx    <= rdIdx;
        slotExt    <= rdExt;
      end
      case (st)
        S_SCAN_ISS: st <= S_SCAN_CAP;
        S_SCAN_CAP: begin
          if (blank) begin
            nextFree <= curAddr;
            st       <= S_IDLE;
          end else if (curAddr == AW'(DEPTH - 1)) begin
            nextFree <= AW'(DEPTH);
            st       <= S_IDLE;
          end else begin
            curAddr <= curAddr + 1'b1;
            st      <= S_SCAN_ISS;
          end
        end
        S_IDLE: begin
          if (slotV) begin
            slotV <= 1'b0;
            if (rdOk) begin
              curAddr <= baseW;
              wordIdx <= '0;
              st      <= S_RD_ISS;
            end else begin
              rdErr <= 1'b1;
            end
          end else if (wrAccept) begin
            curAddr <= nextFree;
            wordIdx <= '0;
            pgmCnt  <= '0;
            st      <= S_PGM;
          end
        end
        S_PGM: begin
          if (pgmLast) begin
            pgmCnt <= '0;
            if (lastWord) begin
              nextFree <= nextFree + AW'(RECW);
              st       <= S_IDLE;
            end else begin
              wordIdx <= wordIdx + 1'b1;
              curAddr <= curAddr + 1'b1;
            end
          end else begin
            pgmCnt <= pgmCnt + 1'b1;
          end
        end
        S_RD_ISS: st <= S_RD_CAP;
        S_RD_CAP: begin
          if (lastWord) begin
            st <= S_RD_DONE;
          end else begin
            wordIdx <= wordIdx + 1'b1;
            curAddr <= curAddr + 1'b1;
            st      <= S_RD_ISS;
          end
        end
        S_RD_DONE: st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  // R2
  pgm_above_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memPgmEn |-> (curAddr >= nextFree));

  // R3
  pgm_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memPgmEn |-> busy);

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memPgmEn && memRdEn));

  // R9
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && full && !busy) |=> !memPgmEn);

  // R10
  ext_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && !slotV && rdIdxReq && !rdLatestReq && rdExt && locked && !wrReq)
      |=> ##1 (rdErr && !rdValid));

endmodule

// File: rtl/otp_append_log.sv
module otp_append_log
  import otp_log_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RECW    = 7,
  parameter int DEPTH   = 64,
  parameter int PGM_CYC = 10000,
  localparam int REC_BITS = DATA_W * RECW,
  localparam int CWW      = DATA_W + 1 + eccChkBits(DATA_W + 1) + 1,
  localparam int MAW      = $clog2(DEPTH),
  localparam int KW       = (RECW > 1) ? $clog2(RECW) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrReq,
  input  logic [REC_BITS-1:0] wrData,
  output logic                wrErr,
  input  logic                rdLatestReq,
  input  logic                rdIdxReq,
  input  logic [MAW-1:0]      rdIdx,
  input  logic                rdExt,
  output logic                rdValid,
  output logic [REC_BITS-1:0] rdData,
  output logic                rdUncorr,
  output logic                rdErr,
  input  logic                lockReq,
  output logic                busy,
  output logic                full,
  output logic [MAW-1:0]      memAddr,
  output logic                memRdEn,
  input  logic [CWW-1:0]      memRdData,
  output logic                memPgmEn,
  output logic [CWW-1:0]      memPgmData
);

  dpStrobe_t     strobe;
  logic [KW-1:0] wordSel;
  logic          blank;

  otp_log_ctrl #(
    .DEPTH(DEPTH), .RECW(RECW), .PGM_CYC(PGM_CYC), .MAW(MAW), .KW(KW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrReq(wrReq), .wrErr(wrErr),
    .rdLatestReq(rdLatestReq), .rdIdxReq(rdIdxReq), .rdIdx(rdIdx), .rdExt(rdExt),
    .rdValid(rdValid), .rdErr(rdErr), .lockReq(lockReq),
    .busy(busy), .full(full), .blank(blank),
    .strobe(strobe), .wordSel(wordSel),
    .memAddr(memAddr), .memRdEn(memRdEn), .memPgmEn(memPgmEn)
  );

  otp_log_dp #(
    .DATA_W(DATA_W), .RECW(RECW), .KW(KW)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wordSel(wordSel), .wrData(wrData),
    .memRdData(memRdData), .memPgmData(memPgmData), .blank(blank),
    .rdData(rdData), .rdUncorr(rdUncorr)
  );

endmodule

// File: tb/otp_append_log_tb.sv
`timescale 1ns/100ps
module otp_append_log_tb;
  localparam int DATA_W  = 16;
  localparam int RECW    = 3;
  localparam int DEPTH   = 16;
  localparam int PGM_CYC = 12;
  localparam int RB      = DATA_W * RECW;
  localparam int CWW     = DATA_W + 1 + otp_log_pkg::eccChkBits(DATA_W + 1) + 1;
  localparam int MAW     = $clog2(DEPTH);

  // {expected full after write, record data}; entry 3 is all ones
  localparam logic [RB:0] TBL [4] = '{
    49'h0_1234_5678_9ABC,
    49'h0_0F0F_A5A5_C3C3,
    49'h0_0000_0000_0001,
    49'h0_FFFF_FFFF_FFFF
  };
  localparam logic [RB-1:0] REC4 = 48'hDEAD_BEEF_7777;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrReq = 0, rdLatestReq = 0, rdIdxReq = 0, rdExt = 0, lockReq = 0;
  logic [RB-1:0] wrData = '0;
  logic [MAW-1:0] rdIdx = '0;
  logic wrErr, rdValid, rdUncorr, rdErr, busy, full, memRdEn, memPgmEn;
  logic [RB-1:0] rdData;
  logic [MAW-1:0] memAddr;
  logic [CWW-1:0] memRdData, memPgmData;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  otp_append_log #(.DATA_W(DATA_W), .RECW(RECW), .DEPTH(DEPTH), .PGM_CYC(PGM_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrData(wrData), .wrErr(wrErr),
    .rdLatestReq(rdLatestReq), .rdIdxReq(rdIdxReq), .rdIdx(rdIdx), .rdExt(rdExt),
    .rdValid(rdValid), .rdData(rdData), .rdUncorr(rdUncorr), .rdErr(rdErr),
    .lockReq(lockReq), .busy(busy), .full(full), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .memPgmEn(memPgmEn), .memPgmData(memPgmData));

  // write-once array model: programming can only clear bits
  logic [CWW-1:0] mem [DEPTH];
  logic injGo = 1'b0;
  logic [MAW-1:0] injAddr = '0;
  logic [CWW-1:0] injMask = '0;
  initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memPgmEn) mem[memAddr] <= mem[memAddr] & memPgmData;
    if (injGo) mem[injAddr] <= mem[injAddr] ^ injMask;
  end

  task automatic note(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // program monitor: duration, order, no reprogramming, no overlap
  int runLen = 0, expNext = 0;
  logic [MAW-1:0] runAddr = '0;
  logic burnt [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) burnt[i] = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memPgmEn && memRdEn) note(1'b0, "R3 read during program", 1, 0);
      if (memPgmEn && !busy) note(1'b0, "R3 busy low during program", 0, 1);
      if (memPgmEn) begin
        if (runLen > 0 && memAddr == runAddr) runLen++;
        else begin
          if (runLen > 0) note(runLen == PGM_CYC, "R3 program length", runLen, PGM_CYC);
          note(!burnt[memAddr] && int'(memAddr) == expNext, "R2 program address", memAddr, expNext);
          burnt[memAddr] = 1'b1;
          expNext++;
          runAddr = memAddr;
          runLen  = 1;
        end
      end else if (runLen > 0) begin
        note(runLen == PGM_CYC, "R3 program length", runLen, PGM_CYC);
        runLen = 0;
      end
    end
  end

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic [RB-1:0] d);
    @(negedge clk);
    wrReq = 1'b1; wrData = d;
    @(negedge clk);
    wrReq = 1'b0;
    waitIdle();
  endtask

  task automatic doRead(input logic latest, input int idx, input logic ext,
                        output logic gotV, output logic gotE, output logic [RB-1:0] d, output logic unc);
    @(negedge clk);
    rdLatestReq = latest; rdIdxReq = !latest; rdIdx = MAW'(idx); rdExt = ext;
    @(negedge clk);
    rdLatestReq = 0; rdIdxReq = 0; rdExt = 0;
    gotV = 0; gotE = 0; d = '0; unc = 0;
    for (int i = 0; i < 2000; i++) begin
      if (rdValid || rdErr) begin
        gotV = rdValid; gotE = rdErr; d = rdData; unc = rdUncorr;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic inject(input int a, input logic [CWW-1:0] m);
    @(negedge clk);
    injGo = 1'b1; injAddr = MAW'(a); injMask = m;
    @(negedge clk);
    injGo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, e, u;
    logic [RB-1:0] d;

    // reset state and scan of a blank array
    repeat (3) @(negedge clk);
    note(busy == 1'b1, "R1 busy during reset", busy, 1);
    rstN = 1'b1;
    @(negedge clk);
    note(busy == 1'b1 && full == 1'b0 && rdValid == 1'b0, "R1 scan start", {busy, full, rdValid}, 3'b100);
    waitIdle();
    note(busy == 1'b0, "R1 scan ends", busy, 0);
    doRead(1'b1, 0, 1'b0, v, e, d, u);
    note(e && !v, "R5 latest on empty array refused", {v, e}, 2'b01);

    // table walk: append, read latest, check full
    for (int i = 0; i < 4; i++) begin
      doWrite(TBL[i][RB-1:0]);
      doRead(1'b1, 0, 1'b0, v, e, d, u);
      note(v && !e && d == TBL[i][RB-1:0], "R5 latest after append", d, TBL[i][RB-1:0]);
      note(full == TBL[i][RB], "R9 full after append", full, TBL[i][RB]);
    end
    note(expNext == 12, "R2 words programmed", expNext, 12);

    // write 5th record; during programming a read and a second write arrive
    @(negedge clk);
    wrReq = 1'b1; wrData = REC4;
    @(negedge clk);
    wrReq = 1'b0;
    repeat (3) @(negedge clk);
    rdIdxReq = 1'b1; rdIdx = '0; wrReq = 1'b1; wrData = 48'h1111_2222_3333;
    @(negedge clk);
    rdIdxReq = 1'b0; wrReq = 1'b0;
    note(wrErr == 1'b1, "R9 write while busy refused", wrErr, 1);
    for (int i = 0; i < 2000 && !rdValid; i++) @(negedge clk);
    note(rdValid && full && !memPgmEn, "R4 pending read served after record", {rdValid, full, memPgmEn}, 3'b110);
    note(rdData == TBL[0][RB-1:0], "R4 pending read data", rdData, TBL[0][RB-1:0]);
    waitIdle();
    note(full == 1'b1 && expNext == 15, "R9 full with one blank word left", expNext, 15);

    // write when full
    @(negedge clk);
    wrReq = 1'b1; wrData = 48'hABCD_ABCD_ABCD;
    @(negedge clk);
    wrReq = 1'b0;
    note(wrErr == 1'b1, "R9 write when full refused", wrErr, 1);
    repeat (30) @(negedge clk);
    note(expNext == 15 && !busy, "R9 nothing programmed when full", expNext, 15);

    // indexed reads
    doRead(1'b0, 2, 1'b0, v, e, d, u);
    note(v && d == TBL[2][RB-1:0], "R6 read index 2", d, TBL[2][RB-1:0]);
    doRead(1'b0, 4, 1'b0, v, e, d, u);
    note(v && d == REC4, "R6 read index 4", d, REC4);
    doRead(1'b0, 5, 1'b0, v, e, d, u);
    note(e && !v, "R6 index beyond pointer refused", {v, e}, 2'b01);

    // rebuild pointer from a written array (record 3 is all ones)
    doReset();
    @(negedge clk);
    note(busy == 1'b1, "R1 rescan busy", busy, 1);
    waitIdle();
    note(full == 1'b1, "R1 pointer rebuilt, full", full, 1);
    doRead(1'b1, 0, 1'b0, v, e, d, u);
    note(v && d == REC4, "R1 latest after rescan", d, REC4);
    doRead(1'b0, 3, 1'b0, v, e, d, u);
    note(v && d == TBL[3][RB-1:0], "R1 all-ones record kept", d, TBL[3][RB-1:0]);

    // error injection
    inject(4, CWW'(1) << 6);
    doRead(1'b0, 1, 1'b0, v, e, d, u);
    note(v && d == TBL[1][RB-1:0], "R7 single bit corrected", d, TBL[1][RB-1:0]);
    note(u == 1'b0, "R7 no uncorrectable flag", u, 0);
    inject(6, (CWW'(1) << 1) | (CWW'(1) << 12));
    doRead(1'b0, 2, 1'b0, v, e, d, u);
    note(v && u, "R8 double bit flagged", {v, u}, 2'b11);
    doRead(1'b0, 1, 1'b0, v, e, d, u);
    note(v && !u, "R8 flag cleared on clean record", {v, u}, 2'b10);

    // lock
    doRead(1'b0, 0, 1'b1, v, e, d, u);
    note(v && d == TBL[0][RB-1:0], "R10 external read before lock", d, TBL[0][RB-1:0]);
    @(negedge clk); lockReq = 1'b1;
    @(negedge clk); lockReq = 1'b0;
    doRead(1'b0, 0, 1'b1, v, e, d, u);
    note(e && !v, "R10 external read refused", {v, e}, 2'b01);
    doRead(1'b1, 0, 1'b0, v, e, d, u);
    note(v && d == REC4, "R10 internal read served", d, REC4);
    @(negedge clk); lockReq = 1'b1;
    @(negedge clk); lockReq = 1'b0;
    doRead(1'b1, 0, 1'b1, v, e, d, u);
    note(e && !v, "R10 lock still set", {v, e}, 2'b01);

    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule